// File: doc/BRIEF.md
# Register Wakeup and Ready Scoreboard

This block sits between rename and issue selection in an out-of-order core. It keeps one ready bit per physical register and a small pool of waiting instruction entries. When an instruction is allocated, each of its source tags is looked up. Any source whose register is still pending is recorded on that register's dependent list. The instruction's destination register is then marked pending, because this instruction is now its producer. When a completion tag arrives, every entry on that register's list has the matching source cleared. The list is emptied and the register becomes ready again.

Each entry runs a small state machine with four states. `ENT_FREE` means unused. `ENT_WAIT` means sources are still outstanding. `ENT_HOLD` means a non-speculative instruction is parked until commit releases it. `ENT_READY` means the entry is eligible for issue.

The transitions are:
- alloc: `ENT_FREE` to `ENT_WAIT`, `ENT_READY` or `ENT_HOLD`.
- wakeup of the last source: `ENT_WAIT` to `ENT_READY`.
- release with a matching sequence number: `ENT_HOLD` to `ENT_READY`.
- grant: `ENT_READY` to `ENT_FREE`.
- flush: any state to `ENT_FREE`.

Ready entries are reported on two vectors. Ordinary instructions appear on `ready_vec`. Memory instructions appear on `mem_ready_vec`, which feeds a separate memory-ordering path.

Top module: `wk_wakeup_scoreboard`

## Requirements
- R1: After reset, all entries are free (`free_count` = NUM_ENTRIES, `full` = 0, both ready vectors zero), and every physical register is ready.
- R2: An accepted allocation takes the lowest-numbered free entry, which is shown on `alloc_idx` before the edge. `free_count` falls by one.
- R3: A source counts as pending only when its valid bit is set, its tag is below NUM_PREGS, and its register is not ready. An entry with no pending source and no non-speculative flag is in ENT_READY one cycle after allocation.
- R4: Allocating with a valid destination tag below NUM_PREGS marks that register pending. A later consumer of that register waits.
- R5: A completion with tag below NUM_PREGS wakes every entry waiting on that register. An entry whose last source is cleared shows ready on the cycle after the completion. The register becomes ready.
- R6: A completion tag at or above NUM_PREGS causes no wakeup and no scoreboard change.
- R7: A source tag that equals an in-range completion tag in the same cycle is treated as ready (bypass).
- R8: A ready memory entry is shown only on `mem_ready_vec`, and a ready non-memory entry only on `ready_vec`.
- R9: A non-speculative entry stays in ENT_HOLD, not ready, until a release arrives whose `rel_seq` equals its sequence number. A release with any other number has no effect on it.
- R10: `full` is 1 exactly when `free_count` is 0. An allocation while full is ignored.
- R11: A grant naming an entry in ENT_READY frees it in the next cycle. A grant naming an entry in any other state has no effect.
- R12: A flush frees all entries and makes every register ready. It takes priority over all other inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all entries and scoreboard |
| alloc_valid | input | 1 | Allocation request |
| alloc_seq | input | SEQ_W | Sequence number of the new instruction |
| alloc_src0_vld | input | 1 | First source present |
| alloc_src0_tag | input | TAG_W | First source physical tag |
| alloc_src1_vld | input | 1 | Second source present |
| alloc_src1_tag | input | TAG_W | Second source physical tag |
| alloc_dst_vld | input | 1 | Destination present |
| alloc_dst_tag | input | TAG_W | Destination physical tag |
| alloc_mem | input | 1 | Instruction is a memory access |
| alloc_nonspec | input | 1 | Instruction must wait for commit release |
| alloc_idx | output | IDX_W | Entry the next allocation will take |
| cpl_valid | input | 1 | Completion present |
| cpl_tag | input | TAG_W | Completed destination tag |
| rel_valid | input | 1 | Commit release present |
| rel_seq | input | SEQ_W | Sequence number being released |
| grant_valid | input | 1 | Issue grant present |
| grant_idx | input | IDX_W | Entry granted by issue selection |
| ready_vec | output | NUM_ENTRIES | Ready non-memory entries |
| mem_ready_vec | output | NUM_ENTRIES | Ready memory entries |
| free_count | output | CNT_W | Number of free entries |
| full | output | 1 | No free entry |

## Verification
Several properties are checked on every cycle:
- the two ready vectors never overlap;
- `full` always agrees with `free_count`;
- an accepted allocation or a valid grant moves `free_count` by exactly one;
- an out-of-range completion on an otherwise idle cycle leaves the ready vector unchanged;
- a flush always empties the pool.

Other behaviour only shows up over sequences of cycles. This covers the exact wakeup order through dependent lists, same-cycle bypass, holding by sequence number, and a register being re-produced while consumers wait. These are covered by the bench's directed scenarios and by a randomized run compared each cycle against a behavioural model.

// File: rtl/wk_pkg.sv
package wk_pkg;
    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_WAIT  = 2'd1,
        ENT_HOLD  = 2'd2,
        ENT_READY = 2'd3
    } ent_state_t;
endpackage

// File: rtl/wk_pick_free.sv
module wk_pick_free #(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] busy,
    output logic                   found,
    output logic [IDX_W-1:0]       idx
);
    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/wk_scoreboard.sv
module wk_scoreboard #(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PREGS   = 64,
    localparam int IDX_W  = $clog2(NUM_ENTRIES),
    localparam int RIDX_W = $clog2(NUM_PREGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   alloc_fire,
    input  logic [IDX_W-1:0]       alloc_idx,
    input  logic                   add0,
    input  logic [RIDX_W-1:0]      add0_reg,
    input  logic                   add1,
    input  logic [RIDX_W-1:0]      add1_reg,
    input  logic                   dst_set,
    input  logic [RIDX_W-1:0]      dst_reg,
    input  logic                   cpl_hit,
    input  logic [RIDX_W-1:0]      cpl_reg,
    output logic [NUM_PREGS-1:0]   reg_ready,
    output logic [NUM_ENTRIES-1:0] wake_vec
);
    // per-register list of dependent entries, kept as an entry bitmask
    logic [NUM_ENTRIES-1:0] dep_q [NUM_PREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_ready <= '1;
            for (int r = 0; r < NUM_PREGS; r++) dep_q[r] <= '0;
        end else if (flush) begin
            reg_ready <= '1;
            for (int r = 0; r < NUM_PREGS; r++) dep_q[r] <= '0;
        end else begin
            if (cpl_hit) begin
                reg_ready[cpl_reg] <= 1'b1;
                dep_q[cpl_reg]     <= '0;
            end
            if (alloc_fire && add0) dep_q[add0_reg][alloc_idx] <= 1'b1;
            if (alloc_fire && add1) dep_q[add1_reg][alloc_idx] <= 1'b1;
            // a new producer overrides a completion of the same register
            if (dst_set) reg_ready[dst_reg] <= 1'b0;
        end
    end

    assign wake_vec = cpl_hit ? dep_q[cpl_reg] : '0;
endmodule

// File: rtl/wk_entry.sv
module wk_entry
    import wk_pkg::*;
#(
    parameter int TAG_W = 7,
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             alloc_here,
    input  logic             alloc_mem,
    input  logic             alloc_nonspec,
    input  logic [SEQ_W-1:0] alloc_seq,
    input  logic             pend0,
    input  logic [TAG_W-1:0] tag0,
    input  logic             pend1,
    input  logic [TAG_W-1:0] tag1,
    input  logic             wake,
    input  logic [TAG_W-1:0] wake_tag,
    input  logic             rel_valid,
    input  logic [SEQ_W-1:0] rel_seq,
    input  logic             grant_here,
    output logic             busy,
    output logic             rdy_alu,
    output logic             rdy_mem
);
    ent_state_t       st_q, st_n;
    logic             w0_q, w0_n, w1_q, w1_n;
    logic [TAG_W-1:0] t0_q, t1_q;
    logic [SEQ_W-1:0] seq_q;
    logic             mem_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ENT_FREE;
            w0_q <= 1'b0;
            w1_q <= 1'b0;
        end else begin
            st_q <= st_n;
            w0_q <= w0_n;
            w1_q <= w1_n;
        end
    end

    // payload captured at allocation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t0_q  <= '0;
            t1_q  <= '0;
            seq_q <= '0;
            mem_q <= 1'b0;
        end else if (alloc_here) begin
            t0_q  <= tag0;
            t1_q  <= tag1;
            seq_q <= alloc_seq;
            mem_q <= alloc_mem;
        end
    end

    // next state
    always_comb begin
        st_n = st_q;
        w0_n = w0_q;
        w1_n = w1_q;
        if (wake && w0_q && (t0_q == wake_tag)) w0_n = 1'b0;
        if (wake && w1_q && (t1_q == wake_tag)) w1_n = 1'b0;
        unique case (st_q)
            ENT_FREE: begin
                if (alloc_here) begin
                    w0_n = pend0 && !alloc_nonspec;
                    w1_n = pend1 && !alloc_nonspec;
                    if (alloc_nonspec)       st_n = ENT_HOLD;
                    else if (pend0 || pend1) st_n = ENT_WAIT;
                    else                     st_n = ENT_READY;
                end
            end
            ENT_WAIT:  if (!w0_n && !w1_n) st_n = ENT_READY;
            ENT_HOLD:  if (rel_valid && (rel_seq == seq_q)) st_n = ENT_READY;
            ENT_READY: if (grant_here) st_n = ENT_FREE;
            default:   st_n = ENT_FREE;
        endcase
        if (flush) begin
            st_n = ENT_FREE;
            w0_n = 1'b0;
            w1_n = 1'b0;
        end
    end

    // outputs
    always_comb begin
        busy    = (st_q != ENT_FREE);
        rdy_alu = (st_q == ENT_READY) && !mem_q;
        rdy_mem = (st_q == ENT_READY) && mem_q;
    end
endmodule

// File: rtl/wk_wakeup_scoreboard.sv
module wk_wakeup_scoreboard #(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PREGS   = 64,
    parameter int TAG_W       = $clog2(NUM_PREGS) + 1,
    parameter int SEQ_W       = 8,
    localparam int IDX_W  = $clog2(NUM_ENTRIES),
    localparam int CNT_W  = $clog2(NUM_ENTRIES + 1),
    localparam int RIDX_W = $clog2(NUM_PREGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   alloc_valid,
    input  logic [SEQ_W-1:0]       alloc_seq,
    input  logic                   alloc_src0_vld,
    input  logic [TAG_W-1:0]       alloc_src0_tag,
    input  logic                   alloc_src1_vld,
    input  logic [TAG_W-1:0]       alloc_src1_tag,
    input  logic                   alloc_dst_vld,
    input  logic [TAG_W-1:0]       alloc_dst_tag,
    input  logic                   alloc_mem,
    input  logic                   alloc_nonspec,
    output logic [IDX_W-1:0]       alloc_idx,
    input  logic                   cpl_valid,
    input  logic [TAG_W-1:0]       cpl_tag,
    input  logic                   rel_valid,
    input  logic [SEQ_W-1:0]       rel_seq,
    input  logic                   grant_valid,
    input  logic [IDX_W-1:0]       grant_idx,
    output logic [NUM_ENTRIES-1:0] ready_vec,
    output logic [NUM_ENTRIES-1:0] mem_ready_vec,
    output logic [CNT_W-1:0]       free_count,
    output logic                   full
);
    localparam logic [TAG_W-1:0] TAG_LIM = TAG_W'(NUM_PREGS);

    logic [NUM_ENTRIES-1:0] busy, wake_vec;
    logic [NUM_PREGS-1:0]   reg_ready;
    logic                   found, alloc_fire, cpl_hit;
    logic                   s0_in, s1_in, d_in, pend0, pend1;

    always_comb begin
        cpl_hit    = cpl_valid && (cpl_tag < TAG_LIM);
        s0_in      = alloc_src0_vld && (alloc_src0_tag < TAG_LIM);
        s1_in      = alloc_src1_vld && (alloc_src1_tag < TAG_LIM);
        d_in       = alloc_dst_vld && (alloc_dst_tag < TAG_LIM);
        // pending unless ready in the scoreboard or completing right now
        pend0      = s0_in && !reg_ready[alloc_src0_tag[RIDX_W-1:0]]
                     && !(cpl_hit && (cpl_tag == alloc_src0_tag));
        pend1      = s1_in && !reg_ready[alloc_src1_tag[RIDX_W-1:0]]
                     && !(cpl_hit && (cpl_tag == alloc_src1_tag));
        alloc_fire = alloc_valid && found && !flush;
        full       = !found;
    end

    always_comb begin
        free_count = '0;
        for (int i = 0; i < NUM_ENTRIES; i++)
            free_count = free_count + (busy[i] ? CNT_W'(0) : CNT_W'(1));
    end

    wk_pick_free #(.NUM_ENTRIES(NUM_ENTRIES)) pick_i (
        .busy  (busy),
        .found (found),
        .idx   (alloc_idx)
    );

    wk_scoreboard #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_PREGS(NUM_PREGS)) sb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .alloc_fire (alloc_fire),
        .alloc_idx  (alloc_idx),
        .add0       (pend0 && !alloc_nonspec),
        .add0_reg   (alloc_src0_tag[RIDX_W-1:0]),
        .add1       (pend1 && !alloc_nonspec),
        .add1_reg   (alloc_src1_tag[RIDX_W-1:0]),
        .dst_set    (alloc_fire && d_in),
        .dst_reg    (alloc_dst_tag[RIDX_W-1:0]),
        .cpl_hit    (cpl_hit),
        .cpl_reg    (cpl_tag[RIDX_W-1:0]),
        .reg_ready  (reg_ready),
        .wake_vec   (wake_vec)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        wk_entry #(.TAG_W(TAG_W), .SEQ_W(SEQ_W)) ent_i (
            .clk           (clk),
            .rst_n         (rst_n),
            .flush         (flush),
            .alloc_here    (alloc_fire && (alloc_idx == IDX_W'(g))),
            .alloc_mem     (alloc_mem),
            .alloc_nonspec (alloc_nonspec),
            .alloc_seq     (alloc_seq),
            .pend0         (pend0),
            .tag0          (alloc_src0_tag),
            .pend1         (pend1),
            .tag1          (alloc_src1_tag),
            .wake          (wake_vec[g]),
            .wake_tag      (cpl_tag),
            .rel_valid     (rel_valid),
            .rel_seq       (rel_seq),
            .grant_here    (grant_valid && (grant_idx == IDX_W'(g))),
            .busy          (busy[g]),
            .rdy_alu       (ready_vec[g]),
            .rdy_mem       (mem_ready_vec[g])
        );
    end
endmodule

// File: rtl/wk_wakeup_scoreboard_chk.sv
module wk_wakeup_scoreboard_chk #(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_PREGS   = 64,
    parameter int TAG_W       = 7,
    localparam int IDX_W = $clog2(NUM_ENTRIES),
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   flush,
    input logic                   alloc_valid,
    input logic                   cpl_valid,
    input logic [TAG_W-1:0]       cpl_tag,
    input logic                   rel_valid,
    input logic                   grant_valid,
    input logic [IDX_W-1:0]       grant_idx,
    input logic [NUM_ENTRIES-1:0] ready_vec,
    input logic [NUM_ENTRIES-1:0] mem_ready_vec,
    input logic [CNT_W-1:0]       free_count,
    input logic                   full
);
    localparam logic [TAG_W-1:0] TAG_LIM = TAG_W'(NUM_PREGS);
    logic granted_ready;
    assign granted_ready = ready_vec[grant_idx] || mem_ready_vec[grant_idx];

    a_r8_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_vec & mem_ready_vec) == '0);

    a_r10_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        full == (free_count == '0));

    a_r2_alloc_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !full && !flush && !grant_valid)
        |=> free_count == $past(free_count) - CNT_W'(1));

    a_r11_grant_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && granted_ready && !alloc_valid && !flush)
        |=> free_count == $past(free_count) + CNT_W'(1));

    a_r6_tag_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && (cpl_tag >= TAG_LIM) && !alloc_valid && !rel_valid
         && !grant_valid && !flush)
        |=> ready_vec == $past(ready_vec));

    a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (free_count == CNT_W'(NUM_ENTRIES)) && (ready_vec == '0)
                  && (mem_ready_vec == '0));
endmodule

bind wk_wakeup_scoreboard wk_wakeup_scoreboard_chk #(
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .alloc_valid   (alloc_valid),
    .cpl_valid     (cpl_valid),
    .cpl_tag       (cpl_tag),
    .rel_valid     (rel_valid),
    .grant_valid   (grant_valid),
    .grant_idx     (grant_idx),
    .ready_vec     (ready_vec),
    .mem_ready_vec (mem_ready_vec),
    .free_count    (free_count),
    .full          (full)
);

// File: tb/wk_wakeup_scoreboard_tb_top.sv
`timescale 1ns/1ps
module wk_wakeup_scoreboard_tb_top;
    localparam int N     = 16;
    localparam int P     = 64;
    localparam int TAG_W = 7;
    localparam int SEQ_W = 8;
    localparam int IDX_W = 4;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             flush = 0, alloc_valid = 0, alloc_src0_vld = 0, alloc_src1_vld = 0;
    logic             alloc_dst_vld = 0, alloc_mem = 0, alloc_nonspec = 0;
    logic [SEQ_W-1:0] alloc_seq = 0, rel_seq = 0;
    logic [TAG_W-1:0] alloc_src0_tag = 0, alloc_src1_tag = 0, alloc_dst_tag = 0, cpl_tag = 0;
    logic             cpl_valid = 0, rel_valid = 0, grant_valid = 0;
    logic [IDX_W-1:0] grant_idx = 0;
    logic [IDX_W-1:0] alloc_idx;
    logic [N-1:0]     ready_vec, mem_ready_vec;
    logic [CNT_W-1:0] free_count;
    logic             full;

    wk_wakeup_scoreboard #(.NUM_ENTRIES(N), .NUM_PREGS(P), .TAG_W(TAG_W), .SEQ_W(SEQ_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
        .alloc_src0_vld(alloc_src0_vld), .alloc_src0_tag(alloc_src0_tag),
        .alloc_src1_vld(alloc_src1_vld), .alloc_src1_tag(alloc_src1_tag),
        .alloc_dst_vld(alloc_dst_vld), .alloc_dst_tag(alloc_dst_tag),
        .alloc_mem(alloc_mem), .alloc_nonspec(alloc_nonspec), .alloc_idx(alloc_idx),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .rel_valid(rel_valid), .rel_seq(rel_seq),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .ready_vec(ready_vec),
        .mem_ready_vec(mem_ready_vec), .free_count(free_count), .full(full)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // state codes: 0 free, 1 waiting, 2 held, 3 ready
    int m_st [N];
    bit m_w0 [N], m_w1 [N], m_mem [N];
    int m_t0 [N], m_t1 [N], m_seq [N];
    bit m_sb [P];

    task automatic m_clear();
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_w0[i] = 0; m_w1[i] = 0;
        end
        for (int r = 0; r < P; r++) m_sb[r] = 1;
    endtask

    function automatic int m_first_free();
        for (int i = 0; i < N; i++) if (m_st[i] == 0) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || flush) begin
            m_clear();
        end else begin
            int f;
            bit cv, p0, p1;
            f  = m_first_free();
            cv = cpl_valid && (int'(cpl_tag) < P);
            p0 = alloc_src0_vld && int'(alloc_src0_tag) < P && !m_sb[int'(alloc_src0_tag) % P]
                 && !(cv && cpl_tag == alloc_src0_tag);
            p1 = alloc_src1_vld && int'(alloc_src1_tag) < P && !m_sb[int'(alloc_src1_tag) % P]
                 && !(cv && cpl_tag == alloc_src1_tag);
            if (grant_valid && m_st[grant_idx] == 3) m_st[grant_idx] = 0;
            if (cv) begin
                for (int i = 0; i < N; i++) if (m_st[i] == 1) begin
                    if (m_w0[i] && m_t0[i] == int'(cpl_tag)) m_w0[i] = 0;
                    if (m_w1[i] && m_t1[i] == int'(cpl_tag)) m_w1[i] = 0;
                end
                m_sb[cpl_tag] = 1;
            end
            for (int i = 0; i < N; i++)
                if (m_st[i] == 1 && !m_w0[i] && !m_w1[i]) m_st[i] = 3;
            if (rel_valid)
                for (int i = 0; i < N; i++)
                    if (m_st[i] == 2 && m_seq[i] == int'(rel_seq)) m_st[i] = 3;
            if (alloc_valid && f >= 0) begin
                m_w0[f]  = p0 && !alloc_nonspec;
                m_w1[f]  = p1 && !alloc_nonspec;
                m_t0[f]  = alloc_src0_tag;
                m_t1[f]  = alloc_src1_tag;
                m_seq[f] = alloc_seq;
                m_mem[f] = alloc_mem;
                m_st[f]  = alloc_nonspec ? 2 : ((m_w0[f] || m_w1[f]) ? 1 : 3);
                if (alloc_dst_vld && int'(alloc_dst_tag) < P) m_sb[alloc_dst_tag] = 0;
            end
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [N-1:0] er, em;
            int fc, ff;
            er = '0; em = '0; fc = 0;
            for (int i = 0; i < N; i++) begin
                if (m_st[i] == 3 && !m_mem[i]) er[i] = 1'b1;
                if (m_st[i] == 3 &&  m_mem[i]) em[i] = 1'b1;
                if (m_st[i] == 0) fc++;
            end
            ff = m_first_free();
            chk("R5 model ready_vec", 64'(ready_vec), 64'(er));
            chk("R8 model mem_ready_vec", 64'(mem_ready_vec), 64'(em));
            chk("R2 model free_count", 64'(free_count), 64'(fc));
            chk("R10 model full", 64'(full), 64'(fc == 0));
            if (ff >= 0) chk("R2 model alloc_idx", 64'(alloc_idx), 64'(ff));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle();
        flush = 0; alloc_valid = 0; alloc_src0_vld = 0; alloc_src1_vld = 0;
        alloc_dst_vld = 0; alloc_mem = 0; alloc_nonspec = 0;
        cpl_valid = 0; rel_valid = 0; grant_valid = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic put(int s0, int s1, int d, bit mem, bit ns, int seq);
        alloc_valid = 1;
        alloc_src0_vld = (s0 >= 0); alloc_src0_tag = (s0 >= 0) ? TAG_W'(s0) : '0;
        alloc_src1_vld = (s1 >= 0); alloc_src1_tag = (s1 >= 0) ? TAG_W'(s1) : '0;
        alloc_dst_vld  = (d >= 0);  alloc_dst_tag  = (d >= 0) ? TAG_W'(d) : '0;
        alloc_mem = mem; alloc_nonspec = ns; alloc_seq = SEQ_W'(seq);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- directed and random scenarios ----------------
    initial begin
        int k;
        int gx;
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        chk("R1 free_count after reset", 64'(free_count), 64'(N));
        chk("R1 full after reset", 64'(full), 0);
        chk("R1 ready_vec after reset", 64'(ready_vec), 0);

        // R3: source on a register ready since reset; producer of reg 10
        put(3, -1, 10, 0, 0, 1);
        chk("R2 first alloc_idx", 64'(alloc_idx), 0);
        cyc(); idle();
        chk("R3 no pending source -> ready", 64'(ready_vec[0]), 1);
        chk("R2 free_count after alloc", 64'(free_count), N - 1);

        // R4: consumer of reg 10 waits
        put(10, -1, 11, 0, 0, 2);
        chk("R2 second alloc_idx", 64'(alloc_idx), 1);
        cyc(); idle(); cyc();
        chk("R4 consumer of pending reg waits", 64'(ready_vec[1]), 0);

        // R6: tag 74 is out of range (74 mod 64 = 10 must not wake)
        cpl_valid = 1; cpl_tag = 7'd74;
        cyc(); idle(); cyc();
        chk("R6 out-of-range completion ignored", 64'(ready_vec[1]), 0);

        // R5: real completion of reg 10
        cpl_valid = 1; cpl_tag = 7'd10;
        cyc(); idle();
        chk("R5 wakeup on completion", 64'(ready_vec[1]), 1);

        // R7: bypass, consumer of reg 11 while 11 completes
        put(11, 11, -1, 0, 0, 3);
        cpl_valid = 1; cpl_tag = 7'd11;
        chk("R2 third alloc_idx", 64'(alloc_idx), 2);
        cyc(); idle();
        chk("R7 same-cycle bypass ready", 64'(ready_vec[2]), 1);

        // R8: memory instruction
        put(-1, -1, -1, 1, 0, 4);
        cyc(); idle();
        chk("R8 memory entry on mem vector", 64'(mem_ready_vec[3]), 1);
        chk("R8 memory entry not on alu vector", 64'(ready_vec[3]), 0);

        // R9: non-speculative held until matching release
        put(-1, -1, 30, 0, 1, 8'h55);
        cyc(); idle(); cyc();
        chk("R9 held after alloc", 64'(ready_vec[4]), 0);
        rel_valid = 1; rel_seq = 8'h54;
        cyc(); idle(); cyc();
        chk("R9 wrong release no effect", 64'(ready_vec[4]), 0);
        rel_valid = 1; rel_seq = 8'h55;
        cyc(); idle();
        chk("R9 matching release readies", 64'(ready_vec[4]), 1);

        // R11: grant of a ready entry frees it
        grant_valid = 1; grant_idx = 0;
        cyc(); idle();
        chk("R11 grant frees entry", 64'(free_count), N - 4);
        // producer of reg 20, then a waiting consumer, then grant the waiter
        put(-1, -1, 20, 0, 0, 9);
        chk("R11 freed entry reused", 64'(alloc_idx), 0);
        cyc(); idle();
        put(20, -1, -1, 0, 0, 10);
        gx = alloc_idx;
        cyc(); idle();
        grant_valid = 1; grant_idx = IDX_W'(gx);
        cyc(); idle(); cyc();
        chk("R11 grant of waiting entry ignored", 64'(free_count), N - 6);

        // R10: fill until full
        k = 0;
        while (!full && k < 2 * N) begin
            put(-1, -1, -1, 0, 0, 11);
            cyc(); idle(); k++;
        end
        chk("R10 full raised", 64'(full), 1);
        chk("R10 free_count zero", 64'(free_count), 0);
        put(-1, -1, -1, 0, 0, 12);
        cyc(); idle(); cyc();
        chk("R10 alloc while full ignored", 64'(free_count), 0);

        // R12: flush
        flush = 1; put(-1, -1, -1, 0, 0, 13);
        cyc(); idle();
        chk("R12 flush frees all", 64'(free_count), N);
        chk("R12 flush clears ready", 64'(ready_vec | mem_ready_vec), 0);
        put(20, -1, -1, 0, 0, 14);
        cyc(); idle();
        chk("R12 flush makes regs ready", 64'(ready_vec[0]), 1);

        // random run, compared against the model every cycle
        for (int c = 0; c < 3000; c++) begin
            int r0, r1;
            idle();
            if ($urandom_range(0, 1) == 1) begin
                r0 = $urandom_range(0, 19); r1 = $urandom_range(0, 19);
                put(($urandom_range(0, 3) == 0) ? -1 : ((r0 > 16) ? r0 + 47 : r0),
                    ($urandom_range(0, 2) == 0) ? -1 : ((r1 > 16) ? r1 + 47 : r1),
                    ($urandom_range(0, 2) == 0) ? -1 : int'($urandom_range(0, 16)),
                    ($urandom_range(0, 4) == 0), ($urandom_range(0, 9) == 0),
                    int'($urandom_range(0, 15)));
            end
            if ($urandom_range(0, 4) < 2) begin
                cpl_valid = 1; cpl_tag = TAG_W'($urandom_range(0, 19) > 16 ?
                                                 $urandom_range(64, 127) : $urandom_range(0, 16));
            end
            if ($urandom_range(0, 4) == 0) begin
                rel_valid = 1; rel_seq = SEQ_W'($urandom_range(0, 15));
            end
            if ($urandom_range(0, 1) == 1) begin
                grant_valid = 1; grant_idx = IDX_W'($urandom_range(0, N - 1));
            end
            if ($urandom_range(0, 199) == 0) flush = 1;
            cyc();
        end
        idle();
        cyc();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule